// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers three hardware events into one level interrupt. The events are a laser pulse having been fired, a MOSFET driver entering its over-temperature warning, and that warning going away. The warning arrives as a raw active-low pin. The block resynchronises it and turns each edge into either an entry event or an exit event.

For every event the block keeps two bits:
- a raw source bit, which records that the event happened whatever the mask says;
- a pending bit, which is gated by a mask bit and drives the interrupt line.

Software reaches the block through a small word-addressed register port. A read or write is a single-cycle strobe. A read returns its data one cycle later, marked by a valid pulse.

Software services an interrupt as follows. It reads the pending and source registers, then writes ones to the pending register. That single write clears the chosen pending bits and their source bits together.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset the source and pending registers read 0, the mask register reads 3'b111, and irq_o is low.
- R2: A one-cycle high on pulse_evt_i always sets source bit 0. It sets pending bit 0 only while mask bit 0 is clear. The bit positions are: bit 0 = pulse, bit 1 = warning entry, bit 2 = warning exit.
- R3: warn_n_i passes through a two-flop synchronizer. A falling edge of the synchronized level sets source bit 1, and a rising edge sets source bit 2. Each of these edges also sets its pending bit when the matching mask bit is clear.
- R4: Writing the pending register (address 1) clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R5: The source register (address 0) is read-only, so writes to it have no effect. A source bit clears in the same cycle that its pending bit is cleared by a write to address 1.
- R6: irq_o is registered and equals the OR of the pending bits. It changes on the same clock edge as the pending register.
- R7: If a hardware event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Bit 0 of the status register (address 3) returns the synchronized level of warn_n_i, so 0 means the warning is active.
- R9: The mask register (address 2, bits 2:0) is read-write. Changing the mask does not alter pending bits that are already set.
- R10: A read strobe in cycle N yields rdata_o and a one-cycle rvalid_o in cycle N+1. With no read strobe, rvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_evt_i | input | 1 | One-cycle strobe: a laser pulse was generated |
| warn_n_i | input | 1 | Asynchronous active-low over-temperature warning pin |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt, OR of pending bits |

## Verification
The pulse event is tried with its mask bit set and with it clear. Comparing the two shows whether the mask gates only the pending bit or wrongly gates the source bit too.

The warning pin is driven through a full low-then-high excursion, both unmasked and masked. This separates entry detection from exit detection and checks that the status bit follows the synchronized level.

Clearing writes are issued in three forms:
- all zeros, which must leave the pending bit alone;
- to the read-only source address, which must change nothing;
- in the same cycle as a fresh pulse, where the set must win.

A final test masks an already pending bit and expects it to stay set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_EVT      = 3;
  localparam int EVT_PULSE    = 0;
  localparam int EVT_OT_ENTER = 1;
  localparam int EVT_OT_EXIT  = 2;

  typedef enum logic [1:0] {
    REG_SRC  = 2'd0,
    REG_PEND = 2'd1,
    REG_MASK = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_warn_sync.sv
module evt_warn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic warn_n_i,
  output logic lvl_o,
  output logic enter_o,
  output logic exit_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // Reset to the inactive (high) level so that no edge appears after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], warn_n_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o   = sh_q[STAGES-1];
  assign enter_o = prev_q & ~lvl_o;
  assign exit_o  = ~prev_q & lvl_o;
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] src_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] pend_d;
  logic [N-1:0] src_d;
  logic [N-1:0] mask_q;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic src_q;
    logic pend_q;

    // A hardware set overrides a software clear arriving in the same cycle.
    assign src_d[i]  = (src_q  & ~clr_i[i]) | evt_i[i];
    assign pend_d[i] = (pend_q & ~clr_i[i]) | (evt_i[i] & ~mask_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        src_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        src_q  <= src_d[i];
        pend_q <= pend_d[i];
      end
    end

    assign src_o[i]  = src_q;
    assign pend_o[i] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_d_i;
      irq_q <= |pend_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/evt_irq_regif.sv
module evt_irq_regif
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int N      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      src_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      mask_i,
  input  logic              lvl_i,
  output logic [N-1:0]      clr_o,
  output logic              mask_wr_o,
  output logic [N-1:0]      mask_d_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(REG_SRC);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(REG_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

  assign clr_o     = (wr_en_i && addr_i == A_PEND) ? wdata_i[N-1:0] : '0;
  assign mask_wr_o = wr_en_i && addr_i == A_MASK;
  assign mask_d_o  = wdata_i[N-1:0];

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_SRC)  rd_mux[N-1:0] = src_i;
    if (addr_i == A_PEND) rd_mux[N-1:0] = pend_i;
    if (addr_i == A_MASK) rd_mux[N-1:0] = mask_i;
    if (addr_i == A_STAT) rd_mux[0]     = lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_evt_i,
  input  logic              warn_n_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic               lvl_w;
  logic               enter_w;
  logic               exit_w;
  logic [NUM_EVT-1:0] evt_w;
  logic [NUM_EVT-1:0] clr_w;
  logic [NUM_EVT-1:0] src_w;
  logic [NUM_EVT-1:0] pend_w;
  logic [NUM_EVT-1:0] mask_w;
  logic [NUM_EVT-1:0] mask_d_w;
  logic               mask_wr_w;

  evt_warn_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .warn_n_i(warn_n_i),
    .lvl_o(lvl_w), .enter_o(enter_w), .exit_o(exit_w)
  );

  always_comb begin
    evt_w               = '0;
    evt_w[EVT_PULSE]    = pulse_evt_i;
    evt_w[EVT_OT_ENTER] = enter_w;
    evt_w[EVT_OT_EXIT]  = exit_w;
  end

  evt_irq_bank #(.N(NUM_EVT)) bank_i (
    .clk(clk), .rst(rst), .evt_i(evt_w), .clr_i(clr_w),
    .mask_wr_i(mask_wr_w), .mask_d_i(mask_d_w),
    .src_o(src_w), .pend_o(pend_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  evt_irq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(NUM_EVT)) regif_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .src_i(src_w), .pend_i(pend_w), .mask_i(mask_w), .lvl_i(lvl_w),
    .clr_o(clr_w), .mask_wr_o(mask_wr_w), .mask_d_o(mask_d_w),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         pulse_evt_i,
  input logic         rd_en_i,
  input logic         rvalid_o,
  input logic         irq_o,
  input logic [N-1:0] src_q,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] mask_q
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (src_q == '0 && pend_q == '0 && mask_q == '1 && !irq_o));

  p_pulse_src_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_evt_i |=> src_q[0]);

  p_masked_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pulse_evt_i && mask_q[0] && !pend_q[0]) |=> !pend_q[0]);

  p_pend_has_src_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~src_q) == '0);

  p_irq_or_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|pend_q));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (pulse_evt_i && !mask_q[0]) |=> pend_q[0]);

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rvalid_o);

  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rvalid_o);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.N(evt_irq_pkg::NUM_EVT)) chk_i (
  .clk(clk), .rst(rst), .pulse_evt_i(pulse_evt_i), .rd_en_i(rd_en_i),
  .rvalid_o(rvalid_o), .irq_o(irq_o),
  .src_q(src_w), .pend_q(pend_w), .mask_q(mask_w)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulse_evt_i = 1'b0;
  logic        warn_n_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_SRC = 2'd0, A_PEND = 2'd1, A_MASK = 2'd2, A_STAT = 2'd3;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .pulse_evt_i(pulse_evt_i), .warn_n_i(warn_n_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o; v = rvalid_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse();
    @(negedge clk); pulse_evt_i = 1'b1;
    @(negedge clk); pulse_evt_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd(a, d, v);
    chk({tag, " rvalid R10"}, {31'd0, v}, 32'd1);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R10 rvalid idle", {31'd0, rvalid_o}, 32'd0);
    rd_chk("R1 source reset", A_SRC, 32'd0);
    rd_chk("R1 pending reset", A_PEND, 32'd0);
    rd_chk("R1 mask reset", A_MASK, 32'd7);
    rd_chk("R8 status idle", A_STAT, 32'd1);
  endtask

  task automatic t_pulse_masked();
    pulse();
    chk("R2 masked irq", {31'd0, irq_o}, 32'd0);
    rd_chk("R2 masked source", A_SRC, 32'd1);
    rd_chk("R2 masked pending", A_PEND, 32'd0);
    wr(A_PEND, 32'd1);
    rd_chk("R5 source cleared by pending W1C", A_SRC, 32'd0);
  endtask

  task automatic t_pulse_unmasked();
    wr(A_MASK, 32'd6);
    rd_chk("R9 mask readback", A_MASK, 32'd6);
    pulse();
    chk("R6 irq same edge", {31'd0, irq_o}, 32'd1);
    rd_chk("R2 unmasked pending", A_PEND, 32'd1);
    rd_chk("R2 unmasked source", A_SRC, 32'd1);
  endtask

  task automatic t_w1c();
    wr(A_PEND, 32'd0);
    rd_chk("R4 zero write keeps pending", A_PEND, 32'd1);
    wr(A_SRC, 32'd7);
    rd_chk("R5 source write ignored", A_SRC, 32'd1);
    wr(A_PEND, 32'd1);
    chk("R6 irq drops on clear", {31'd0, irq_o}, 32'd0);
    rd_chk("R4 pending cleared", A_PEND, 32'd0);
    rd_chk("R5 source cleared", A_SRC, 32'd0);
  endtask

  task automatic t_set_wins();
    pulse();
    @(negedge clk);
    pulse_evt_i = 1'b1; wr_en_i = 1'b1; addr_i = A_PEND; wdata_i = 32'd1;
    @(negedge clk);
    pulse_evt_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
    rd_chk("R7 set wins pending", A_PEND, 32'd1);
    rd_chk("R7 set wins source", A_SRC, 32'd1);
    chk("R7 irq kept", {31'd0, irq_o}, 32'd1);
    wr(A_PEND, 32'd1);
  endtask

  task automatic t_warn();
    wr(A_MASK, 32'd0);
    @(negedge clk); warn_n_i = 1'b0;
    repeat (5) @(negedge clk);
    rd_chk("R8 status warning", A_STAT, 32'd0);
    rd_chk("R3 entry pending", A_PEND, 32'd2);
    rd_chk("R3 entry source", A_SRC, 32'd2);
    chk("R6 irq on entry", {31'd0, irq_o}, 32'd1);
    warn_n_i = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R8 status released", A_STAT, 32'd1);
    rd_chk("R3 exit pending", A_PEND, 32'd6);
    wr(A_PEND, 32'd2);
    rd_chk("R4 partial clear", A_PEND, 32'd4);
    wr(A_PEND, 32'd4);
    rd_chk("R5 all sources clear", A_SRC, 32'd0);
    wr(A_MASK, 32'd7);
    @(negedge clk); warn_n_i = 1'b0;
    repeat (5) @(negedge clk);
    warn_n_i = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R3 masked warn pending", A_PEND, 32'd0);
    rd_chk("R3 masked warn source", A_SRC, 32'd6);
    wr(A_PEND, 32'd6);
    rd_chk("R5 masked source cleared", A_SRC, 32'd0);
  endtask

  task automatic t_mask_keep();
    wr(A_MASK, 32'd0);
    pulse();
    wr(A_MASK, 32'd7);
    rd_chk("R9 pending kept after mask", A_PEND, 32'd1);
    chk("R9 irq kept after mask", {31'd0, irq_o}, 32'd1);
    rd_chk("R9 mask readback all", A_MASK, 32'd7);
    wr(A_PEND, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pulse_masked();
    t_pulse_unmasked();
    t_w1c();
    t_set_wins();
    t_warn();
    t_mask_keep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule